// File: doc/BRIEF.md
# Per-Channel Video CRC Signature Unit

This block sits at the input of the video DACs and builds a 16-bit CRC signature for each of the three colour channels, so that a test program can confirm the whole pixel datapath end to end at full pixel rate. Each channel has its own accumulator and only ever sees its own channel's bytes. Accumulation runs only on active-display pixels, which are the clock cycles where the active-low blanking input `blank_n` is high. The signature is taken from either the live pixel bytes or a built-in test pattern.

A capture is started by a control write with the arm bit set. The write is accepted only after the screen has been blanked long enough for the datapath to settle. An accepted arm reseeds all three accumulators and clears the done flag. The unit then waits for the next active region, accumulates over that one region, and freezes the results when blanking returns. The three signatures and the done flag can be read at any time.

The pixel stream has no valid/ready handshake and no back-pressure, because video cannot be stalled. `blank_n` acts as the per-cycle valid qualifier, every qualified cycle is consumed, and there is no ready output. The control write is a single-cycle strobe.

Top module: `chan_crc_sig`

## Requirements
- R1: After reset, all three signature outputs read 0xFFFF and `sig_done` is 0.
- R2: A completed capture gives, per channel, CRC-16 with polynomial 0x1021 and seed 0xFFFF. Each byte is processed MSB first and XORed into the top byte of the register, with no reflection and no final XOR, over that channel's bytes in pixel order. For example, the ASCII bytes "123456789" give 0x29B1.
- R3: Each channel's signature depends only on that channel's bytes: red on `pix_r`, green on `pix_g` and blue on `pix_b`, or on the matching pattern lane.
- R4: Cycles with `blank_n` = 0 never change any signature, except the reseed of an accepted arm.
- R5: Control bit 1 selects the source and is latched by an accepted arm: 1 selects the live pixel inputs and 0 selects the internal pattern.
- R6: A write with control bit 2 = 1 is an arm request. It is accepted only if `blank_n` is 0 in the write cycle and was also 0 in each of at least the 10 cycles just before it. Any other arm request is ignored, and it leaves the signatures and `sig_done` unchanged.
- R7: On the clock edge of an accepted arm, all three signatures become 0xFFFF and `sig_done` becomes 0.
- R8: After an accepted arm, exactly one active region is accumulated, from the first cycle with `blank_n` = 1 to the next cycle with `blank_n` = 0. On that clock edge `sig_done` becomes 1. The signatures and `sig_done` then hold until the next accepted arm, whatever later pixels arrive.
- R9: Pattern source: let k be the pixel's index within its active region, counting from 0 and taken modulo 256. The red lane is k, the green lane is (k + 0x55) mod 256 and the blue lane is the bitwise inverse of k.
- R10: One byte per channel is folded in every active cycle, with no stall. This holds for regions longer than 256 pixels.
- R11: A control write with bit 2 = 0 has no effect on the signatures or on `sig_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_r | input | 8 | Red pixel byte |
| pix_g | input | 8 | Green pixel byte |
| pix_b | input | 8 | Blue pixel byte |
| blank_n | input | 1 | Active-low blanking; 1 marks an active-display pixel |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_wdata | input | 3 | Control data: bit 2 arm, bit 1 source (1 live, 0 pattern), bit 0 unused |
| sig_r | output | 16 | Red signature |
| sig_g | output | 16 | Green signature |
| sig_b | output | 16 | Blue signature |
| sig_done | output | 1 | Capture complete; signatures frozen |

## Verification
The bound checker checks several rules on every clock edge:
- blanked cycles never change a signature;
- a frozen capture stays frozen and done;
- an accepted arm always reseeds and clears done;
- an arm request is accepted exactly when the blanking run has reached ten cycles and the write itself falls in blanking;
- done only rises at the start of blanking.

Only the directed scenarios can show that the signature values are correct against a bytewise model, including the standard check string and a pattern region that wraps past 256 pixels. The same scenarios show that the source bit is honoured and that a second active region after done leaves the result untouched.

// File: rtl/crcsig_pkg.sv
package crcsig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } crcsig_state_e;

  localparam int CRCSIG_NCH = 3;

endpackage

// File: rtl/crcsig_lane.sv
module crcsig_lane #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_en,
  input  logic          upd_en,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] sig
);

  localparam int PAD_W = CW - DW;

  logic [CW-1:0] nxt;

  // whole byte folded in one cycle: DW serial shift steps unrolled
  always_comb begin
    nxt = sig ^ {din, {PAD_W{1'b0}}};
    for (int k = 0; k < DW; k++) begin
      if (nxt[CW-1]) nxt = (nxt << 1) ^ POLY;
      else           nxt = nxt << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sig <= SEED;
    else if (seed_en) sig <= SEED;
    else if (upd_en)  sig <= nxt;
  end

endmodule

// File: rtl/crcsig_pattern.sv
module crcsig_pattern #(
  parameter int NCH = 3,
  parameter int DW = 8,
  parameter logic [DW-1:0] G_OFS = 8'h55
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blank_n,
  output logic [NCH-1:0][DW-1:0]  pat
);

  logic [DW-1:0] idx;

  // idx holds the position of the current pixel inside its active region
  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (blank_n) idx <= idx + 1'b1;
    else              idx <= '0;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_lane
      if (c == 0) begin : g_red
        assign pat[c] = idx;
      end else if (c == 1) begin : g_green
        assign pat[c] = idx + G_OFS;
      end else if (c == 2) begin : g_blue
        assign pat[c] = ~idx;
      end else begin : g_extra
        assign pat[c] = idx ^ DW'(c);
      end
    end
  endgenerate

endmodule

// File: rtl/crcsig_seq.sv
module crcsig_seq
  import crcsig_pkg::*;
#(
  parameter int SETTLE  = 10,
  parameter int CTL_W   = 3,
  parameter int ARM_BIT = 2,
  parameter int SRC_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             arm_ok,
  output logic             acc_en,
  output logic             src_live,
  output logic             sig_done
);

  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);

  logic [CNT_W-1:0] blank_cnt;
  logic             settled;
  logic             arm_req;
  logic             ctl_unused;
  crcsig_state_e    st, st_nxt;

  assign ctl_unused = ^ctl_wdata;

  // run length of blanked cycles, saturating at the settle length
  always_ff @(posedge clk) begin
    if (!rst_n)        blank_cnt <= '0;
    else if (blank_n)  blank_cnt <= '0;
    else if (!settled) blank_cnt <= blank_cnt + 1'b1;
  end

  assign settled = (blank_cnt >= CNT_MAX);
  assign arm_req = ctl_wr & ctl_wdata[ARM_BIT];
  assign arm_ok  = arm_req & ~blank_n & settled;
  assign acc_en  = blank_n & ((st == ST_ARMED) | (st == ST_RUN));

  always_comb begin
    st_nxt = st;
    if (arm_ok) begin
      st_nxt = ST_ARMED;
    end else begin
      case (st)
        ST_ARMED: if (blank_n)  st_nxt = ST_RUN;
        ST_RUN:   if (!blank_n) st_nxt = ST_DONE;
        default:  st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_live <= 1'b0;
      sig_done <= 1'b0;
    end else begin
      st <= st_nxt;
      if (arm_ok) begin
        src_live <= ctl_wdata[SRC_BIT];
        sig_done <= 1'b0;
      end else if (st == ST_RUN && !blank_n) begin
        sig_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/chan_crc_sig.sv
module chan_crc_sig
  import crcsig_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter logic [CW-1:0] SEED = 16'hFFFF,
  parameter int SETTLE  = 10,
  parameter int CTL_W   = 3,
  parameter int ARM_BIT = 2,
  parameter int SRC_BIT = 1,
  parameter logic [DW-1:0] G_OFS = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    pix_r,
  input  logic [DW-1:0]    pix_g,
  input  logic [DW-1:0]    pix_b,
  input  logic             blank_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CW-1:0]    sig_r,
  output logic [CW-1:0]    sig_g,
  output logic [CW-1:0]    sig_b,
  output logic             sig_done
);

  localparam int NCH = CRCSIG_NCH;

  logic                   arm_ok;
  logic                   acc_en;
  logic                   src_live;
  logic [NCH-1:0][DW-1:0] pix_bus;
  logic [NCH-1:0][DW-1:0] pat_bus;
  logic [NCH-1:0][DW-1:0] lane_in;
  logic [NCH-1:0][CW-1:0] sig_bus;

  assign pix_bus = {pix_b, pix_g, pix_r};

  crcsig_seq #(
    .SETTLE (SETTLE),
    .CTL_W  (CTL_W),
    .ARM_BIT(ARM_BIT),
    .SRC_BIT(SRC_BIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank_n  (blank_n),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .arm_ok   (arm_ok),
    .acc_en   (acc_en),
    .src_live (src_live),
    .sig_done (sig_done)
  );

  crcsig_pattern #(
    .NCH  (NCH),
    .DW   (DW),
    .G_OFS(G_OFS)
  ) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .blank_n(blank_n),
    .pat    (pat_bus)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign lane_in[ch] = src_live ? pix_bus[ch] : pat_bus[ch];

      crcsig_lane #(
        .DW  (DW),
        .CW  (CW),
        .POLY(POLY),
        .SEED(SEED)
      ) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_en(arm_ok),
        .upd_en (acc_en),
        .din    (lane_in[ch]),
        .sig    (sig_bus[ch])
      );
    end
  endgenerate

  assign sig_r = sig_bus[0];
  assign sig_g = sig_bus[1];
  assign sig_b = sig_bus[2];

endmodule

// File: rtl/crcsig_chk.sv
module crcsig_chk #(
  parameter int SETTLE = 10,
  parameter int CW     = 16,
  parameter logic [CW-1:0] SEED = 16'hFFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blank_n,
  input logic          arm_req,
  input logic          arm_ok,
  input logic [CW-1:0] sig_r,
  input logic [CW-1:0] sig_g,
  input logic [CW-1:0] sig_b,
  input logic          sig_done
);

  localparam int RUN_W = $clog2(SETTLE + 1);

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                          run_len <= '0;
    else if (blank_n)                    run_len <= '0;
    else if (run_len < RUN_W'(SETTLE))   run_len <= run_len + 1'b1;
  end

  // R4
  p_hold_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n && !arm_ok) |=> ($stable(sig_r) && $stable(sig_g) && $stable(sig_b)));

  // R8
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_done && !arm_ok) |=> (sig_done && $stable(sig_r) && $stable(sig_g) && $stable(sig_b)));

  p_done_at_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_done) |-> !$past(blank_n));

  // R7
  p_reseed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (sig_r == SEED && sig_g == SEED && sig_b == SEED && !sig_done));

  // R6
  p_early_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && (blank_n || run_len < RUN_W'(SETTLE))) |-> !arm_ok);

  p_settled_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !blank_n && run_len >= RUN_W'(SETTLE)) |-> arm_ok);

endmodule

bind chan_crc_sig crcsig_chk #(
  .SETTLE(SETTLE),
  .CW    (CW),
  .SEED  (SEED)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .blank_n (blank_n),
  .arm_req (ctl_wr & ctl_wdata[ARM_BIT]),
  .arm_ok  (arm_ok),
  .sig_r   (sig_r),
  .sig_g   (sig_g),
  .sig_b   (sig_b),
  .sig_done(sig_done)
);

// File: tb/chan_crc_sig_tb_top.sv
`timescale 1ns/1ps
module chan_crc_sig_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        blank_n;
  logic        ctl_wr;
  logic [2:0]  ctl_wdata;
  logic [15:0] sig_r, sig_g, sig_b;
  logic        sig_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  chan_crc_sig dut_i (
    .clk(clk), .rst_n(rst_n),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .blank_n(blank_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sig_r(sig_r), .sig_g(sig_g), .sig_b(sig_b), .sig_done(sig_done)
  );

  function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] v;
    v = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) v = v[15] ? ((v << 1) ^ 16'h1021) : (v << 1);
    return v;
  endfunction

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [15:0] er, logic [15:0] eg,
                         logic [15:0] eb, logic ed);
    chk({tag, " sig_r"}, sig_r, er);
    chk({tag, " sig_g"}, sig_g, eg);
    chk({tag, " sig_b"}, sig_b, eb);
    chk({tag, " sig_done"}, {15'd0, sig_done}, {15'd0, ed});
  endtask

  // drive one cycle after a falling edge; returns at the next falling edge
  task automatic cyc(logic bn, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                     logic wr, logic [2:0] wd);
    blank_n = bn; pix_r = r; pix_g = g; pix_b = b;
    ctl_wr = wr; ctl_wdata = wd;
    @(negedge clk);
  endtask

  task automatic blanks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'(i * 13), 8'(i + 7), 8'(~i), 1'b0, 3'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0);
    blanks(3);
    rst_n = 1'b1;
    chk_all("R1 reset", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
  endtask

  task automatic t_known_vector;
    logic [7:0]  txt [9];
    logic [15:0] er, eg, eb;
    txt = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    blanks(12);
    cyc(1'b0, 8'h11, 8'h22, 8'h33, 1'b1, 3'b110);
    chk_all("R7 arm live", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    blanks(3);
    chk_all("R4 blank wait", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    er = 16'hFFFF; eg = 16'hFFFF; eb = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin
      er = ref_step(er, txt[i]);
      eg = ref_step(eg, 8'(i * 7 + 3));
      eb = ref_step(eb, 8'hF0 ^ 8'(i));
      cyc(1'b1, txt[i], 8'(i * 7 + 3), 8'hF0 ^ 8'(i), 1'b0, 3'd0);
    end
    chk("R3 not done mid region", {15'd0, sig_done}, 16'd0);
    blanks(1);
    chk("R2 check string", sig_r, 16'h29B1);
    chk_all("R2 R3 live capture", er, eg, eb, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'(i + 90), 8'(i * 3), 8'h5A, 1'b0, 3'd0);
    blanks(2);
    chk_all("R8 second region ignored", er, eg, eb, 1'b1);
  endtask

  task automatic t_pattern;
    logic [15:0] er, eg, eb;
    logic [7:0]  k;
    blanks(10);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 3'b100);
    chk_all("R7 arm pattern", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    blanks(1);
    er = 16'hFFFF; eg = 16'hFFFF; eb = 16'hFFFF;
    for (int i = 0; i < 300; i++) begin
      k  = 8'(i);
      er = ref_step(er, k);
      eg = ref_step(eg, k + 8'h55);
      eb = ref_step(eb, ~k);
      cyc(1'b1, 8'hA5, 8'h3C, 8'(i * 5), 1'b0, 3'd0);
    end
    blanks(1);
    chk_all("R5 R9 R10 pattern capture", er, eg, eb, 1'b1);
  endtask

  task automatic t_arm_rules;
    logic [15:0] hr, hg, hb, er;
    hr = sig_r; hg = sig_g; hb = sig_b;
    cyc(1'b1, 8'h01, 8'h02, 8'h03, 1'b0, 3'd0);
    blanks(9);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 3'b110);
    chk_all("R6 arm after 9 blanks ignored", hr, hg, hb, 1'b1);
    cyc(1'b1, 8'h44, 8'h55, 8'h66, 1'b1, 3'b110);
    chk_all("R6 arm in active ignored", hr, hg, hb, 1'b1);
    blanks(10);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 3'b010);
    chk_all("R11 write without arm bit", hr, hg, hb, 1'b1);
    cyc(1'b1, 8'h07, 8'h08, 8'h09, 1'b0, 3'd0);
    blanks(10);
    cyc(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 3'b110);
    chk_all("R6 R7 arm after exactly 10 blanks", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    cyc(1'b1, 8'h00, 8'hC3, 8'hFF, 1'b0, 3'd0);
    blanks(1);
    er = ref_step(16'hFFFF, 8'h00);
    chk_all("R2 R5 single pixel live", er, ref_step(16'hFFFF, 8'hC3),
            ref_step(16'hFFFF, 8'hFF), 1'b1);
  endtask

  initial begin
    blank_n = 1'b0; pix_r = '0; pix_g = '0; pix_b = '0;
    ctl_wr = 1'b0; ctl_wdata = '0; rst_n = 1'b0;
    @(negedge clk);
    t_reset;
    t_known_vector;
    t_pattern;
    t_arm_rules;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule